// File: doc/BRIEF.md
# Power-Up Memory Boot Sequencer

This block brings a small programmable audio processor out of reset. When its active-low reset input is released, it makes one pass over a shared 10-bit address range. In each cycle of the pass it writes three memories at the same address. The program RAM gets the word from the program boot ROM. The parameter RAM gets the word from the parameter boot ROM. The data memory gets zero. The ROM read ports are combinational: the block presents an address and takes the returned word in the same cycle.

For the whole pass a busy output is high. While busy is high, the host register port cannot make reads or writes take effect. This includes the master-clock input selector, which returns to input 0 on every reset. After the last write the block pulses done for one cycle and raises core enable, which lets the processor core start. If reset is asserted part-way through the pass, the writes stop at once and the pass starts again from address 0 on the next release.

Top module: `boot_seq`

## Requirements
- R1: While rst_n is low, the three write enables, done and core_en are low and busy is high.
- R2: On the first clock edge that samples rst_n high, a pass begins. It lasts exactly 1024 cycles. In each of these cycles all three write enables are high with one shared address, which runs 0, 1, … 1023 in ascending order. No write enable is high outside the pass.
- R3: In every pass cycle, prog_ram_wdata equals prog_rom_data for prog_rom_addr. prog_rom_addr equals the write address.
- R4: In every pass cycle, par_ram_wdata equals par_rom_data for par_rom_addr. par_rom_addr equals the write address.
- R5: In every pass cycle, dmem_wdata is zero, so the pass leaves every data-memory word cleared.
- R6: busy stays high from the reset release through the cycle of the final write, and is low afterwards.
- R7: done is high for exactly one cycle: the cycle after the final write. core_en rises in that same cycle and stays high until rst_n is next low.
- R8: host_wr_ok equals host_wr and host_rd_ok equals host_rd while busy is low. Both are low while busy is high.
- R9: mclk_sel is 0 after reset. A host write made while busy is high leaves it unchanged. An accepted write loads host_sel_wdata at the next clock edge.
- R10: When rst_n goes low during a pass, all write enables drop in the same cycle, with no clock edge needed. The next release restarts the pass from address 0 and runs a full 1024 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low reset; its release starts a pass |
| prog_rom_addr | output | 10 | Program boot ROM read address |
| prog_rom_data | input | 24 | Program boot ROM read data (same cycle) |
| par_rom_addr | output | 10 | Parameter boot ROM read address |
| par_rom_data | input | 16 | Parameter boot ROM read data (same cycle) |
| prog_ram_we | output | 1 | Program RAM write enable |
| prog_ram_addr | output | 10 | Program RAM write address |
| prog_ram_wdata | output | 24 | Program RAM write data |
| par_ram_we | output | 1 | Parameter RAM write enable |
| par_ram_addr | output | 10 | Parameter RAM write address |
| par_ram_wdata | output | 16 | Parameter RAM write data |
| dmem_we | output | 1 | Data memory write enable |
| dmem_addr | output | 10 | Data memory write address |
| dmem_wdata | output | 28 | Data memory write data (always zero) |
| busy | output | 1 | Pass in progress or reset held |
| done | output | 1 | One-cycle pulse after the final write |
| core_en | output | 1 | Core may run |
| host_wr | input | 1 | Host register write request |
| host_rd | input | 1 | Host register read request |
| host_sel_wdata | input | 2 | Clock-selector value carried by a host write |
| host_wr_ok | output | 1 | Host write allowed to take effect |
| host_rd_ok | output | 1 | Host read allowed to take effect |
| mclk_sel | output | 2 | Master-clock input selector |

## Verification
The ROMs are loaded with fresh random words before each pass. The memories are first filled with values that differ from the expected result, so a missed address, a skipped copy or a clear that never happens shows up as a stale word.

The bench runs several kinds of pass. Full passes run with and without host requests issued while busy is high. Aborted passes stop at a random address, at the first write and at the last write. These tell a restart from address 0 apart from a resume at the aborted address. They also tell an immediate stop of the writes apart from a stop one edge late.

Host writes made after done show that the lockout lifts exactly when busy falls. Reset checks show that the selector returns to input 0.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;

    localparam int BOOT_ADDR_W = 10;
    localparam int BOOT_PROG_W = 24;
    localparam int BOOT_PAR_W  = 16;
    localparam int BOOT_DMEM_W = 28;
    localparam int BOOT_SEL_W  = 2;

    typedef enum logic [1:0] {
        ST_HOLD = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } boot_state_e;

    // Next phase of the boot pass; called only while reset is released.
    function automatic boot_state_e boot_next(input boot_state_e cur, input logic at_last);
        boot_state_e nxt;
        case (cur)
            ST_HOLD: nxt = ST_RUN;
            ST_RUN:  nxt = at_last ? ST_DONE : ST_RUN;
            ST_DONE: nxt = ST_DONE;
            default: nxt = ST_HOLD;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/boot_ctrl.sv
module boot_ctrl
    import boot_seq_pkg::*;
#(
    parameter int ADDR_W = BOOT_ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    output boot_state_e       state_o,
    output logic [ADDR_W-1:0] cnt_o,
    output logic              done_o
);

    boot_state_e       st;
    logic [ADDR_W-1:0] cnt;
    logic              at_last;

    assign at_last = &cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_HOLD;
            cnt    <= '0;
            done_o <= 1'b0;
        end else begin
            st     <= boot_next(st, at_last);
            done_o <= (st == ST_RUN) && at_last;
            if (st == ST_HOLD) begin
                cnt <= '0;
            end else if (st == ST_RUN && !at_last) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign state_o = st;
    assign cnt_o   = cnt;

endmodule

// File: rtl/boot_wrport.sv
module boot_wrport #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 16
) (
    input  logic              rst_n,
    input  logic              run_i,
    input  logic [ADDR_W-1:0] cnt_i,
    input  logic [DATA_W-1:0] src_i,
    output logic              we_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] data_o
);

    // Gating with rst_n drops the write in the cycle reset falls.
    assign we_o   = run_i & rst_n;
    assign addr_o = cnt_i;
    assign data_o = src_i;

endmodule

// File: rtl/host_gate.sv
module host_gate #(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             busy_i,
    input  logic             wr_i,
    input  logic             rd_i,
    input  logic [SEL_W-1:0] wdata_i,
    output logic             wr_ok_o,
    output logic             rd_ok_o,
    output logic [SEL_W-1:0] sel_o
);

    assign wr_ok_o = wr_i & ~busy_i;
    assign rd_ok_o = rd_i & ~busy_i;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_o <= '0;
        end else if (wr_ok_o) begin
            sel_o <= wdata_i;
        end
    end

endmodule

// File: rtl/boot_seq.sv
module boot_seq
    import boot_seq_pkg::*;
#(
    parameter int ADDR_W = BOOT_ADDR_W,
    parameter int PROG_W = BOOT_PROG_W,
    parameter int PAR_W  = BOOT_PAR_W,
    parameter int DMEM_W = BOOT_DMEM_W,
    parameter int SEL_W  = BOOT_SEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] prog_rom_addr,
    input  logic [PROG_W-1:0] prog_rom_data,
    output logic [ADDR_W-1:0] par_rom_addr,
    input  logic [PAR_W-1:0]  par_rom_data,
    output logic              prog_ram_we,
    output logic [ADDR_W-1:0] prog_ram_addr,
    output logic [PROG_W-1:0] prog_ram_wdata,
    output logic              par_ram_we,
    output logic [ADDR_W-1:0] par_ram_addr,
    output logic [PAR_W-1:0]  par_ram_wdata,
    output logic              dmem_we,
    output logic [ADDR_W-1:0] dmem_addr,
    output logic [DMEM_W-1:0] dmem_wdata,
    output logic              busy,
    output logic              done,
    output logic              core_en,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [SEL_W-1:0]  host_sel_wdata,
    output logic              host_wr_ok,
    output logic              host_rd_ok,
    output logic [SEL_W-1:0]  mclk_sel
);

    boot_state_e       st;
    logic [ADDR_W-1:0] cnt;
    logic              run;

    boot_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .state_o (st),
        .cnt_o   (cnt),
        .done_o  (done)
    );

    assign run     = (st == ST_RUN);
    assign busy    = (st != ST_DONE);
    assign core_en = (st == ST_DONE);

    assign prog_rom_addr = cnt;
    assign par_rom_addr  = cnt;

    boot_wrport #(.ADDR_W(ADDR_W), .DATA_W(PROG_W)) u_prog (
        .rst_n  (rst_n),
        .run_i  (run),
        .cnt_i  (cnt),
        .src_i  (prog_rom_data),
        .we_o   (prog_ram_we),
        .addr_o (prog_ram_addr),
        .data_o (prog_ram_wdata)
    );

    boot_wrport #(.ADDR_W(ADDR_W), .DATA_W(PAR_W)) u_par (
        .rst_n  (rst_n),
        .run_i  (run),
        .cnt_i  (cnt),
        .src_i  (par_rom_data),
        .we_o   (par_ram_we),
        .addr_o (par_ram_addr),
        .data_o (par_ram_wdata)
    );

    boot_wrport #(.ADDR_W(ADDR_W), .DATA_W(DMEM_W)) u_dmem (
        .rst_n  (rst_n),
        .run_i  (run),
        .cnt_i  (cnt),
        .src_i  ({DMEM_W{1'b0}}),
        .we_o   (dmem_we),
        .addr_o (dmem_addr),
        .data_o (dmem_wdata)
    );

    host_gate #(.SEL_W(SEL_W)) u_host (
        .clk     (clk),
        .rst_n   (rst_n),
        .busy_i  (busy),
        .wr_i    (host_wr),
        .rd_i    (host_rd),
        .wdata_i (host_sel_wdata),
        .wr_ok_o (host_wr_ok),
        .rd_ok_o (host_rd_ok),
        .sel_o   (mclk_sel)
    );

endmodule

// File: rtl/boot_seq_chk.sv
module boot_seq_chk #(
    parameter int ADDR_W = 10,
    parameter int SEL_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              prog_ram_we,
    input logic [ADDR_W-1:0] prog_ram_addr,
    input logic              par_ram_we,
    input logic              dmem_we,
    input logic              busy,
    input logic              done,
    input logic              core_en,
    input logic              host_wr_ok,
    input logic              host_rd_ok,
    input logic [SEL_W-1:0]  mclk_sel
);

    always @(negedge clk) begin
        if (!rst_n) begin
            AST_RESET_NO_WRITE: assert (!(prog_ram_we || par_ram_we || dmem_we)); // R10
        end
    end

    AST_ADDR_ASCENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_ram_we && $past(prog_ram_we)) |-> (prog_ram_addr == ADDR_W'($past(prog_ram_addr) + 1'b1))); // R2

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7

    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(prog_ram_we && (&prog_ram_addr))); // R7

    AST_CORE_STAYS_ON: assert property (@(posedge clk) disable iff (!rst_n)
        core_en |=> core_en); // R7

    AST_HOST_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (!host_wr_ok && !host_rd_ok)); // R8

    AST_SEL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(mclk_sel)); // R9

endmodule

bind boot_seq boot_seq_chk #(.ADDR_W(ADDR_W), .SEL_W(SEL_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .prog_ram_we   (prog_ram_we),
    .prog_ram_addr (prog_ram_addr),
    .par_ram_we    (par_ram_we),
    .dmem_we       (dmem_we),
    .busy          (busy),
    .done          (done),
    .core_en       (core_en),
    .host_wr_ok    (host_wr_ok),
    .host_rd_ok    (host_rd_ok),
    .mclk_sel      (mclk_sel)
);

// File: tb/boot_seq_test.sv
`timescale 1ns/1ps
module boot_seq_test;

    localparam int AW = 10;
    localparam int PW = 24;
    localparam int QW = 16;
    localparam int DW = 28;
    localparam int SW = 2;
    localparam int N  = 1 << AW;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          rst_n;
    logic [AW-1:0] prog_rom_addr, par_rom_addr;
    logic [PW-1:0] prog_rom_data;
    logic [QW-1:0] par_rom_data;
    logic          prog_ram_we, par_ram_we, dmem_we;
    logic [AW-1:0] prog_ram_addr, par_ram_addr, dmem_addr;
    logic [PW-1:0] prog_ram_wdata;
    logic [QW-1:0] par_ram_wdata;
    logic [DW-1:0] dmem_wdata;
    logic          busy, done, core_en;
    logic          host_wr, host_rd, host_wr_ok, host_rd_ok;
    logic [SW-1:0] host_sel_wdata, mclk_sel;

    logic [PW-1:0] prog_rom [N];
    logic [QW-1:0] par_rom  [N];
    logic [PW-1:0] prog_ram [N];
    logic [QW-1:0] par_ram  [N];
    logic [DW-1:0] dmem     [N];

    assign prog_rom_data = prog_rom[prog_rom_addr];
    assign par_rom_data  = par_rom[par_rom_addr];

    always @(posedge clk) begin
        if (prog_ram_we) prog_ram[prog_ram_addr] <= prog_ram_wdata;
        if (par_ram_we)  par_ram[par_ram_addr]   <= par_ram_wdata;
        if (dmem_we)     dmem[dmem_addr]         <= dmem_wdata;
    end

    boot_seq uut (
        .clk(clk), .rst_n(rst_n),
        .prog_rom_addr(prog_rom_addr), .prog_rom_data(prog_rom_data),
        .par_rom_addr(par_rom_addr), .par_rom_data(par_rom_data),
        .prog_ram_we(prog_ram_we), .prog_ram_addr(prog_ram_addr), .prog_ram_wdata(prog_ram_wdata),
        .par_ram_we(par_ram_we), .par_ram_addr(par_ram_addr), .par_ram_wdata(par_ram_wdata),
        .dmem_we(dmem_we), .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata),
        .busy(busy), .done(done), .core_en(core_en),
        .host_wr(host_wr), .host_rd(host_rd), .host_sel_wdata(host_sel_wdata),
        .host_wr_ok(host_wr_ok), .host_rd_ok(host_rd_ok), .mclk_sel(mclk_sel)
    );

    int total = 0;
    int bad   = 0;

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [PW-1:0] exp_prog(int a);
        return prog_rom[a];
    endfunction

    function automatic logic [QW-1:0] exp_par(int a);
        return par_rom[a];
    endfunction

    function automatic logic [DW-1:0] exp_dmem(int a);
        return (a >= 0) ? '0 : '1;
    endfunction

    task automatic fill_mems();
        for (int i = 0; i < N; i++) begin
            prog_rom[i] = PW'($urandom);
            par_rom[i]  = QW'($urandom);
            prog_ram[i] = ~prog_rom[i];
            par_ram[i]  = ~par_rom[i];
            dmem[i]     = DW'($urandom) | DW'(1);
        end
    endtask

    task automatic do_reset(int n);
        rst_n = 1'b0;
        host_wr = 1'b0;
        host_rd = 1'b0;
        #1;
        check("R10", "we at reset fall", {29'd0, prog_ram_we, par_ram_we, dmem_we}, 32'd0);
        repeat (n) begin
            @(negedge clk);
            #1;
            check("R1", "we in reset", {29'd0, prog_ram_we, par_ram_we, dmem_we}, 32'd0);
            check("R1", "busy in reset", busy, 1);
            check("R1", "done in reset", done, 0);
            check("R1", "core_en in reset", core_en, 0);
            check("R9", "mclk_sel default", mclk_sel, 0);
        end
    endtask

    task automatic run_full(bit host_noise);
        rst_n = 1'b1;
        for (int cyc = 1; cyc <= N + 2; cyc++) begin
            logic ew;
            @(negedge clk);
            host_wr = 1'b0;
            host_rd = 1'b0;
            #1;
            ew = (cyc <= N);
            check("R2", "prog we", prog_ram_we, ew);
            check("R2", "par we", par_ram_we, ew);
            check("R2", "dmem we", dmem_we, ew);
            if (ew) begin
                check("R2", "prog addr", prog_ram_addr, cyc - 1);
                check("R2", "par addr", par_ram_addr, cyc - 1);
                check("R2", "dmem addr", dmem_addr, cyc - 1);
                check("R3", "prog rom addr", prog_rom_addr, cyc - 1);
                check("R4", "par rom addr", par_rom_addr, cyc - 1);
                check("R3", "prog wdata", prog_ram_wdata, exp_prog(cyc - 1));
                check("R4", "par wdata", par_ram_wdata, exp_par(cyc - 1));
                check("R5", "dmem wdata", dmem_wdata, exp_dmem(cyc - 1));
            end
            check("R6", "busy", busy, ew);
            check("R7", "done", done, (cyc == N + 1));
            check("R7", "core_en", core_en, (cyc > N));
            check("R9", "mclk_sel during pass", mclk_sel, 0);
            if (host_noise && ew && $urandom_range(0, 3) == 0) begin
                host_wr = 1'b1;
                host_rd = 1'b1;
                host_sel_wdata = SW'($urandom_range(1, 3));
                #1;
                check("R8", "wr_ok while busy", host_wr_ok, 0);
                check("R8", "rd_ok while busy", host_rd_ok, 0);
            end
        end
        begin
            int mp, mq, md;
            mp = 0; mq = 0; md = 0;
            for (int i = 0; i < N; i++) begin
                if (prog_ram[i] !== exp_prog(i)) mp++;
                if (par_ram[i] !== exp_par(i))   mq++;
                if (dmem[i] !== exp_dmem(i))     md++;
            end
            check("R3", "prog ram mismatches", mp, 0);
            check("R4", "par ram mismatches", mq, 0);
            check("R5", "dmem mismatches", md, 0);
        end
    endtask

    task automatic run_abort(int at);
        rst_n = 1'b1;
        for (int cyc = 1; cyc <= at; cyc++) begin
            @(negedge clk);
            #1;
            check("R2", "we before abort", prog_ram_we, 1);
            check("R2", "addr before abort", prog_ram_addr, cyc - 1);
        end
        rst_n = 1'b0;
        #1;
        check("R10", "writes stop at abort", {29'd0, prog_ram_we, par_ram_we, dmem_we}, 32'd0);
        check("R10", "busy at abort", busy, 1);
        do_reset($urandom_range(1, 4));
    endtask

    task automatic host_after();
        @(negedge clk);
        host_wr = 1'b1;
        host_rd = 1'b1;
        host_sel_wdata = 2'd2;
        #1;
        check("R8", "wr_ok when idle", host_wr_ok, 1);
        check("R8", "rd_ok when idle", host_rd_ok, 1);
        @(negedge clk);
        host_wr = 1'b0;
        host_rd = 1'b0;
        #1;
        check("R8", "wr_ok follows request", host_wr_ok, 0);
        check("R9", "mclk_sel loaded", mclk_sel, 2);
    endtask

    initial begin
        void'($urandom(32'h5EED_0A17));
        rst_n = 1'b0;
        host_wr = 1'b0;
        host_rd = 1'b0;
        host_sel_wdata = '0;
        do_reset(3);
        fill_mems();
        run_full(1'b0);
        host_after();

        do_reset(2);
        fill_mems();
        run_full(1'b1);

        do_reset(2);
        fill_mems();
        run_abort($urandom_range(50, 1000));
        run_full(1'b1);

        do_reset(1);
        fill_mems();
        run_abort(1);
        run_full(1'b0);

        do_reset(2);
        fill_mems();
        run_abort(N);
        run_full(1'b1);
        host_after();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule